// File: doc/BRIEF.md
# Acknowledge-clocked tone code serializer

This block sits between a tone decoder and a host controller. The decoder supplies a 4-bit key code and a detect flag that goes high while a valid tone is present. The host reads the code one bit at a time. Each rising edge on the host's acknowledge line moves one bit onto a single serial data pin, least significant bit first. There is no valid/ready handshake and no back-pressure. The host sets the pace entirely through its acknowledge pulses, and the block never stalls or drops a code on its own.

The acknowledge and power-down lines are asynchronous to the system clock. Each passes through a two-flop synchronizer, and the block reacts to the rising edges it detects. A pulse counter, running from 0 to 4, tracks how far a read has progressed. The first counted pulse captures the code. The next three pulses shift out the remaining bits. After that the counter stays full, and any further pulses are ignored until the detect flag rises again. The counter clears on a new tone only after a complete read. A read that stops early therefore throws the next read out of step. Four dummy pulses with no tone present bring the counter back to full from any count.

A rising edge on the power-down line puts the block to sleep, but only if acknowledge is low at that moment. While asleep, the serial output is held low and acknowledge pulses have no effect. Taking the power-down line low wakes the block and re-arms the counter. If the same tone is still held, the host can then read it again. The decoder is expected to map keys to codes as follows: 1 to 9 give 1 to 9, 0 gives 10, star gives 11, hash gives 12, and A, B, C, D give 13, 14, 15 and 0.

Top module: `ack_tone_serializer`

## Requirements
- R1: After reset, `sd_o` and `pd_o` are both low, and the pulse counter is at 0.
- R2: When the counter is at 0, an acknowledge rising edge captures `tone_code_i`. Bit 0 of the captured code then appears on `sd_o` three clock cycles after the rising edge reaches the `ack_i` pin.
- R3: The second, third and fourth counted acknowledge edges put bits 1, 2 and 3 of the captured code on `sd_o`. `sd_o` holds its value between pulses.
- R4: After four counted edges the counter stays full. Further acknowledge edges leave `sd_o` unchanged.
- R5: A low-to-high transition of `tone_valid_i` while the counter is full clears the counter. The next four pulses then read the new code.
- R6: A transition of `tone_valid_i` from low to high does not clear a partly advanced counter (1 to 3). The next pulses continue the old sequence and put the remaining high bits of the previously captured code on `sd_o`.
- R7: Four acknowledge pulses with no tone present bring the counter to full from any count. The next tone is then read correctly.
- R8: A rising edge on `pwdn_i` while `ack_i` is low sets `pd_o` high. While `pd_o` is high, `sd_o` is low.
- R9: A rising edge on `pwdn_i` while `ack_i` is high does not enter power-down.
- R10: In power-down, acknowledge pulses change neither the counter nor the output. When `pwdn_i` goes low, `pd_o` falls and the counter clears. A held code can then be read again, so n sleep cycles allow n+1 reads of one tone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tone_code_i | input | CODE_W (4) | Key code from the tone decoder |
| tone_valid_i | input | 1 | Detect flag from the decoder, high while a valid tone is held |
| ack_i | input | 1 | Host acknowledge pulses, asynchronous |
| pwdn_i | input | 1 | Power-down request, asynchronous |
| sd_o | output | 1 | Serial code bit, low in power-down |
| pd_o | output | 1 | High while the block is in power-down |

## Verification
Clean four-pulse reads are run with codes whose bit patterns differ at every position, so any swap or misordering of bits shows up. Extra pulses after a full read separate a counter that saturates from one that wraps around. A read cut short, followed by a new tone, separates "counter cleared by the tone" from "counter carries over", because the old and new codes differ in their high bits. Sleep cycles that toggle acknowledge while asleep, then read again, show that power-down re-arms the counter but does not advance it. A power-down request made while acknowledge is high shows that the entry guard works.

// File: rtl/tone_ser_pkg.sv
package tone_ser_pkg;
  parameter int TONE_CODE_W = 4;

  // Keypad character to 4-bit code as produced by the upstream decoder.
  function automatic logic [3:0] key_to_code(input byte k);
    logic [3:0] c;
    if (k >= "1" && k <= "9") c = 4'(k - "0");
    else if (k == "0") c = 4'd10;
    else if (k == "*") c = 4'd11;
    else if (k == "#") c = 4'd12;
    else if (k == "A") c = 4'd13;
    else if (k == "B") c = 4'd14;
    else if (k == "C") c = 4'd15;
    else c = 4'd0;
    return c;
  endfunction
endpackage

// File: rtl/tone_ser_edge_sync.sv
module tone_ser_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic rise
);
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[STAGES-1:0], din};
  end

  assign lvl  = pipe[STAGES-1];
  assign rise = pipe[STAGES-1] & ~pipe[STAGES];
endmodule

// File: rtl/tone_ser_pwdn_ctrl.sv
module tone_ser_pwdn_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic pwdn_lvl,
  input  logic pwdn_rise,
  input  logic ack_lvl,
  output logic pd,
  output logic pd_exit
);
  always_ff @(posedge clk) begin
    if (!rst_n)                       pd <= 1'b0;
    else if (!pwdn_lvl)               pd <= 1'b0;
    else if (pwdn_rise && !ack_lvl)   pd <= 1'b1;
  end

  // Leaving sleep this cycle: re-arms the pulse counter.
  assign pd_exit = pd & ~pwdn_lvl;
endmodule

// File: rtl/tone_ser_pulse_counter.sv
module tone_ser_pulse_counter #(
  parameter  int CODE_W = 4,
  localparam int CNT_W  = $clog2(CODE_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  logic             ack_rise,
  input  logic             pd,
  input  logic             pd_exit,
  output logic [CNT_W-1:0] cnt,
  output logic             valid_rise,
  output logic             take
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(CODE_W);

  logic valid_q;

  assign valid_rise = valid_i & ~valid_q;
  assign take       = ~pd & ack_rise & (cnt != FULL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_i;
      if (pd_exit)                              cnt <= '0;
      else if (!pd && valid_rise && cnt == FULL) cnt <= '0;
      else if (take)                             cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/tone_ser_shifter.sv
module tone_ser_shifter #(
  parameter  int CODE_W = 4,
  localparam int CNT_W  = $clog2(CODE_W + 1),
  localparam int IDX_W  = $clog2(CODE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code_i,
  input  logic              take,
  input  logic [CNT_W-1:0]  cnt,
  output logic              sd_q
);
  logic [CODE_W-1:0] hold;
  logic [IDX_W-1:0]  idx;

  assign idx = cnt[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold <= '0;
      sd_q <= 1'b0;
    end else if (take) begin
      if (cnt == '0) begin
        hold <= code_i;
        sd_q <= code_i[0];
      end else begin
        sd_q <= hold[idx];
      end
    end
  end
endmodule

// File: rtl/ack_tone_serializer.sv
module ack_tone_serializer
  import tone_ser_pkg::*;
#(
  parameter int CODE_W      = TONE_CODE_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] tone_code_i,
  input  logic              tone_valid_i,
  input  logic              ack_i,
  input  logic              pwdn_i,
  output logic              sd_o,
  output logic              pd_o
);
  localparam int CNT_W = $clog2(CODE_W + 1);

  logic             ack_lvl, ack_rise, pwdn_lvl, pwdn_rise;
  logic             pd, pd_exit, take, valid_rise, sd_q;
  logic [CNT_W-1:0] pulse_cnt;

  tone_ser_edge_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .din(ack_i), .lvl(ack_lvl), .rise(ack_rise));

  tone_ser_edge_sync #(.STAGES(SYNC_STAGES)) u_pwdn_sync (
    .clk(clk), .rst_n(rst_n), .din(pwdn_i), .lvl(pwdn_lvl), .rise(pwdn_rise));

  tone_ser_pwdn_ctrl u_pwdn (
    .clk(clk), .rst_n(rst_n), .pwdn_lvl(pwdn_lvl), .pwdn_rise(pwdn_rise),
    .ack_lvl(ack_lvl), .pd(pd), .pd_exit(pd_exit));

  tone_ser_pulse_counter #(.CODE_W(CODE_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .valid_i(tone_valid_i), .ack_rise(ack_rise),
    .pd(pd), .pd_exit(pd_exit), .cnt(pulse_cnt), .valid_rise(valid_rise),
    .take(take));

  tone_ser_shifter #(.CODE_W(CODE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .code_i(tone_code_i), .take(take),
    .cnt(pulse_cnt), .sd_q(sd_q));

  assign sd_o = pd ? 1'b0 : sd_q;
  assign pd_o = pd;
endmodule

// File: rtl/tone_ser_checker.sv
module tone_ser_checker #(
  parameter int CNT_W = 3,
  parameter int FULL  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sd,
  input logic             pd,
  input logic             ack_lvl,
  input logic             ack_rise,
  input logic             pwdn_lvl,
  input logic             valid_rise,
  input logic [CNT_W-1:0] cnt
);
  AST_SD_LOW_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    pd |-> !sd); // R8

  AST_ENTRY_ACK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd) |-> !$past(ack_lvl)); // R9

  AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(FULL)); // R4

  AST_EXTRA_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!pd && cnt == CNT_W'(FULL) && ack_rise && !valid_rise)
      |=> (cnt == CNT_W'(FULL)) && $stable(sd)); // R4

  AST_ASLEEP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (pd && pwdn_lvl) |=> $stable(cnt)); // R10

  AST_WAKE_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pd) |-> cnt == '0); // R10

  AST_PARTIAL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (!pd && valid_rise && cnt != '0 && cnt != CNT_W'(FULL) && !ack_rise)
      |=> $stable(cnt)); // R6
endmodule

bind ack_tone_serializer tone_ser_checker #(.CNT_W(CNT_W), .FULL(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sd(sd_o), .pd(pd_o), .ack_lvl(ack_lvl),
  .ack_rise(ack_rise), .pwdn_lvl(pwdn_lvl), .valid_rise(valid_rise),
  .cnt(pulse_cnt));

// File: tb/ack_tone_serializer_tb.sv
`timescale 1ns/1ps
module ack_tone_serializer_tb;
  import tone_ser_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] code = 4'd0;
  logic       valid = 1'b0;
  logic       ack = 1'b0;
  logic       pwdn = 1'b0;
  logic       sd_o, pd_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ack_tone_serializer u_dut (
    .clk(clk), .rst_n(rst_n), .tone_code_i(code), .tone_valid_i(valid),
    .ack_i(ack), .pwdn_i(pwdn), .sd_o(sd_o), .pd_o(pd_o));

  // Behavioural reference: input history queues, integer pulse count.
  bit ah[$];
  bit ph[$];
  bit vprev;
  int m_cnt;
  bit [3:0] m_code;
  bit m_sd, m_pd;

  always @(posedge clk) begin
    if (!rst_n) begin
      ah = '{0, 0, 0}; ph = '{0, 0, 0};
      vprev = 0; m_cnt = 0; m_code = 0; m_sd = 0; m_pd = 0;
    end else begin
      bit a_lvl, a_rise, p_lvl, p_rise, v_rise;
      a_lvl  = ah[1];
      a_rise = ah[1] && !ah[2];
      p_lvl  = ph[1];
      p_rise = ph[1] && !ph[2];
      v_rise = valid && !vprev;
      if (m_pd) begin
        if (!p_lvl) begin m_pd = 0; m_cnt = 0; end
      end else begin
        if (v_rise && m_cnt == 4) m_cnt = 0;
        else if (a_rise && m_cnt < 4) begin
          if (m_cnt == 0) begin m_code = code; m_sd = code[0]; end
          else m_sd = m_code[m_cnt];
          m_cnt++;
        end
        if (p_rise && !a_lvl) m_pd = 1;
      end
      vprev = valid;
      ah.push_front(ack); void'(ah.pop_back());
      ph.push_front(pwdn); void'(ph.pop_back());
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_vec++;
      if (sd_o !== (m_pd ? 1'b0 : m_sd) || pd_o !== m_pd) begin
        n_bad++;
        $display("FAIL model: sd=%0b pd=%0b expected sd=%0b pd=%0b at %0t",
                 sd_o, pd_o, m_pd ? 1'b0 : m_sd, m_pd, $time);
      end
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pulse();
    @(negedge clk) ack = 1'b1;
    repeat (4) @(negedge clk);
    ack = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic new_tone(input byte key);
    @(negedge clk) valid = 1'b0;
    repeat (3) @(negedge clk);
    code = key_to_code(key);
    valid = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic read4(input string req, input logic [3:0] exp);
    for (int b = 0; b < 4; b++) begin
      pulse();
      chk(req, sd_o, exp[b]);
    end
  endtask

  task automatic sleep_cycle(input int toggles);
    @(negedge clk) pwdn = 1'b1;
    repeat (5) @(negedge clk);
    chk("R8 pd", pd_o, 1'b1);
    chk("R8 sd", sd_o, 1'b0);
    for (int t = 0; t < toggles; t++) begin
      pulse();
      chk("R10 asleep sd", sd_o, 1'b0);
    end
    pwdn = 1'b0;
    repeat (5) @(negedge clk);
    chk("R10 woke", pd_o, 1'b0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk("R1 sd", sd_o, 1'b0);
    chk("R1 pd", pd_o, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 sd idle", sd_o, 1'b0);

    // R2 R3: clean read of 7 (0111)
    new_tone("7");
    read4("R2 R3 code7", 4'b0111);
    // R4: extra pulses hold bit 3
    pulse(); chk("R4 extra", sd_o, 1'b0);
    pulse(); chk("R4 extra", sd_o, 1'b0);

    // R5: new tone after full read, hash = 12 (1100)
    new_tone("#");
    read4("R5 hash", 4'b1100);

    // R6: partial read of A (1101), then tone 8 (1000)
    new_tone("A");
    pulse(); chk("R6 partial b0", sd_o, 1'b1);
    pulse(); chk("R6 partial b1", sd_o, 1'b0);
    new_tone("8");
    pulse(); chk("R6 carry old b2", sd_o, 1'b1);
    pulse(); chk("R6 carry old b3", sd_o, 1'b1);
    pulse(); chk("R6 then ignored", sd_o, 1'b1);

    // R7: partial read of 2, then four dummy pulses with no tone
    new_tone("2");
    pulse(); chk("R7 partial b0", sd_o, 1'b0);
    @(negedge clk) valid = 1'b0;
    repeat (4) pulse();
    new_tone("9");
    read4("R7 after dummies", 4'b1001);

    // R8 R10: zero = 10 (1010), read three times with two sleep cycles
    new_tone("0");
    read4("R10 read1", 4'b1010);
    sleep_cycle(3);
    read4("R10 read2", 4'b1010);
    sleep_cycle(0);
    read4("R10 read3", 4'b1010);

    // R9: power-down request while ack high is refused
    @(negedge clk) ack = 1'b1;
    repeat (4) @(negedge clk);
    pwdn = 1'b1;
    repeat (6) @(negedge clk);
    chk("R9 no entry", pd_o, 1'b0);
    chk("R9 sd held", sd_o, 1'b1);
    ack = 1'b0;
    repeat (4) @(negedge clk);
    pwdn = 1'b0;
    repeat (4) @(negedge clk);
    chk("R9 still awake", pd_o, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule